// File: doc/BRIEF.md
# SDRAM Command Bus Monitor and Mode Checker

This block sits beside an SDRAM command bus and only listens. On every rising clock edge it samples the clock enable, the four active-low strobes, the bank select and the address lines. It turns each sample into one command and follows a simplified model of the device state. It keeps a shadow copy of the last accepted mode word and reports the burst length and CAS latency that word selects. It raises sticky error flags, with a first-error code, when something goes wrong. Two kinds of fault are caught: a mode word that holds a reserved encoding, and a command that the tracked state does not allow. A rejected mode word is reported before it is adopted, so the shadow copy never describes an undefined mode.

The tracker has six states. UNINIT is the state after reset. PRECHG is entered from UNINIT on any precharge. MODE_SET is entered from PRECHG or IDLE on an accepted mode load. It lasts exactly one cycle and always moves on to IDLE. IDLE moves to ACTIVE on an activate. ACTIVE returns to IDLE when a precharge closes the last open bank, or when a precharge closes all banks. SELF_REF is entered from IDLE on a refresh command sampled with clock enable low, and it returns to IDLE on the first cycle with clock enable high. Every other command either leaves the state where it is or is reported as an error. Per-bank open-row flags back the ACTIVE state. A wrapping counter of mode-register loads is also kept.

Top module: `sdram_bus_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as follows: 0000 mode load, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 no-op. With cs_n high (inhibit), or with cke low, the sample has no effect. The one exception is the refresh pattern with cke low, which is the self-refresh entry.
- R2: After reset, state_o is 0 (UNINIT), all error flags and err_code_o are 0, burst_len_o and cas_lat_o are 0, and mode_loads_o is 0. state_o encodes the states as UNINIT=0, PRECHG=1, MODE_SET=2, IDLE=3, ACTIVE=4, SELF_REF=5.
- R3: A precharge in UNINIT moves to PRECHG. An accepted mode load in PRECHG or IDLE moves to MODE_SET. MODE_SET always moves to IDLE on the next cycle.
- R4: The burst-length code addr[2:0] maps 000 to 1, 001 to 2, 010 to 4 and 011 to 8. Code 111 with addr[3]=0 means full page and is reported as burst_len_o=0. Codes 100, 101 and 110 are rejected, and so is 111 with addr[3]=1. A rejection sets err_mode_o and gives code 1.
- R5: The CAS latency code addr[6:4] maps 010 to cas_lat_o=2 and 011 to cas_lat_o=3. Any other value sets err_mode_o and gives code 2.
- R6: An operating-mode field addr[8:7] other than 00 sets err_mode_o and gives code 3.
- R7: A nonzero addr[11:10] in a mode load sets err_field_o and gives code 4, without setting err_mode_o.
- R8: A rejected mode load leaves mode_word_o, burst_len_o, cas_lat_o and the state unchanged.
- R9: A read or write in UNINIT or PRECHG sets err_seq_o with code 5. The following also set err_seq_o, with code 6: any command other than a precharge in UNINIT (except a no-op), an activate or burst stop in PRECHG, any non-no-op command in MODE_SET, and a mode load, refresh or self-refresh entry in ACTIVE.
- R10: A read or write to a bank with no open row, in IDLE or ACTIVE, sets err_proto_o with code 7. An activate to a bank whose row is already open sets err_proto_o with code 8 and changes nothing else.
- R11: In ACTIVE, a precharge with addr[10]=1 closes all banks and returns to IDLE. A precharge with addr[10]=0 closes only the selected bank, and the state returns to IDLE only if that bank was the last one open.
- R12: A refresh with cke low in IDLE enters SELF_REF. While cke stays low the state is held and nothing is decoded. The first cycle with cke high returns to IDLE.
- R13: Error flags are sticky. err_code_o keeps the first error seen since reset or since the last clear; within one cycle the lowest code wins. A pulse on err_clr clears all flags and the code. An error in the same cycle as the clear is still recorded.
- R14: mode_loads_o counts every mode-load command sampled outside SELF_REF, accepted or not, and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Sampled chip select, active low |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write enable, active low |
| ba | input | BA_W | Sampled bank select |
| addr | input | ADDR_W | Sampled address / mode word |
| err_clr | input | 1 | Clears the error flags and the code |
| state_o | output | 3 | Tracked device state |
| mode_word_o | output | 12 | Last accepted mode word |
| burst_len_o | output | 4 | Decoded burst length (0 = full page or none) |
| cas_lat_o | output | 2 | Decoded CAS latency (0 = none) |
| mode_loads_o | output | CNT_W | Count of mode-load commands |
| err_mode_o | output | 1 | Reserved encoding in a mode load |
| err_field_o | output | 1 | Nonzero reserved field in a mode load |
| err_seq_o | output | 1 | Command illegal in the tracked state |
| err_proto_o | output | 1 | Bank open/closed violation |
| err_code_o | output | 4 | Code of the first error |

## Verification
The bench builds the monitor with BA_W=2, which gives four banks. With four banks it can open several rows at once and check that a single-bank precharge returns to IDLE only when the last row closes. ADDR_W is 12, so the mode word fills the whole address and the bank-wide precharge bit sits at position 10. CNT_W is 3, so eight mode loads wrap the counter, and the wrap is checked in the same run as rejected loads that still count.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_AREF,
        CMD_SREF,
        CMD_LMR
    } sdm_cmd_e;

    typedef enum logic [2:0] {
        ST_UNINIT  = 3'd0,
        ST_PRECHG  = 3'd1,
        ST_MODESET = 3'd2,
        ST_IDLE    = 3'd3,
        ST_ACTIVE  = 3'd4,
        ST_SELFREF = 3'd5
    } sdm_state_e;

    localparam logic [3:0] EC_NONE   = 4'd0;
    localparam logic [3:0] EC_BL     = 4'd1;
    localparam logic [3:0] EC_CL     = 4'd2;
    localparam logic [3:0] EC_OP     = 4'd3;
    localparam logic [3:0] EC_FIELD  = 4'd4;
    localparam logic [3:0] EC_EARLY  = 4'd5;
    localparam logic [3:0] EC_STATE  = 4'd6;
    localparam logic [3:0] EC_CLOSED = 4'd7;
    localparam logic [3:0] EC_REOPEN = 4'd8;

endpackage

// File: rtl/sdm_cmd_decode.sv
module sdm_cmd_decode
    import sdm_pkg::*;
(
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdm_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (cs_n) begin
            cmd = CMD_NOP;
        end else if (!cke) begin
            cmd = ({ras_n, cas_n, we_n} == 3'b001) ? CMD_SREF : CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = CMD_LMR;
                3'b001: cmd = CMD_AREF;
                3'b010: cmd = CMD_PRE;
                3'b011: cmd = CMD_ACT;
                3'b100: cmd = CMD_WR;
                3'b101: cmd = CMD_RD;
                3'b110: cmd = CMD_BST;
                3'b111: cmd = CMD_NOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdm_mode_check.sv
module sdm_mode_check (
    input  logic [2:0] bl_code,
    input  logic       interleave,
    input  logic [2:0] cl_code,
    input  logic [1:0] op_code,
    input  logic [1:0] rsv_code,
    output logic       bl_bad,
    output logic       cl_bad,
    output logic       op_bad,
    output logic       field_bad,
    output logic [3:0] bl_val,
    output logic [1:0] cl_val
);

    always_comb begin
        bl_bad = 1'b0;
        bl_val = 4'd0;
        unique case (bl_code)
            3'b000: bl_val = 4'd1;
            3'b001: bl_val = 4'd2;
            3'b010: bl_val = 4'd4;
            3'b011: bl_val = 4'd8;
            3'b111: bl_bad = interleave;
            default: bl_bad = 1'b1;
        endcase
    end

    always_comb begin
        cl_bad = 1'b0;
        cl_val = 2'd0;
        unique case (cl_code)
            3'b010: cl_val = 2'd2;
            3'b011: cl_val = 2'd3;
            default: cl_bad = 1'b1;
        endcase
    end

    assign op_bad    = (op_code != 2'b00);
    assign field_bad = (rsv_code != 2'b00);

endmodule

// File: rtl/sdm_bank_track.sv
module sdm_bank_track #(
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_en,
    input  logic            close_en,
    input  logic            close_all,
    input  logic [BA_W-1:0] bank,
    output logic [(1<<BA_W)-1:0] open_q,
    output logic            sel_open,
    output logic            last_open
);

    localparam int NB = 1 << BA_W;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
            end else if (close_all) begin
                open_q[g] <= 1'b0;
            end else if (open_en && (bank == BA_W'(g))) begin
                open_q[g] <= 1'b1;
            end else if (close_en && (bank == BA_W'(g))) begin
                open_q[g] <= 1'b0;
            end
        end
    end

    assign sel_open  = open_q[bank];
    assign last_open = (open_q == (NB'(1) << bank));

    // R10: the controlling FSM never asks to open a row that is already open
    p_no_reopen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |-> !sel_open);

    // R11: a precharge-all leaves every bank closed
    p_close_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> (open_q == '0));

endmodule

// File: rtl/sdram_bus_monitor.sv
module sdram_bus_monitor
    import sdm_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              err_clr,
    output logic [2:0]        state_o,
    output logic [11:0]       mode_word_o,
    output logic [3:0]        burst_len_o,
    output logic [1:0]        cas_lat_o,
    output logic [CNT_W-1:0]  mode_loads_o,
    output logic              err_mode_o,
    output logic              err_field_o,
    output logic              err_seq_o,
    output logic              err_proto_o,
    output logic [3:0]        err_code_o
);

    localparam int NB     = 1 << BA_W;
    localparam int AP_BIT = 10;

    sdm_cmd_e          cmd;
    sdm_state_e        st_q, st_n;
    logic              bl_bad, cl_bad, op_bad, field_bad;
    logic [3:0]        bl_val;
    logic [1:0]        cl_val;
    logic              mode_ok, lmr_seen, accept_lmr;
    logic              open_en, close_en, close_all;
    logic [NB-1:0]     open_q;
    logic              sel_open, last_open;
    logic [3:0]        ec, mec, new_code;
    logic [MODE_W-1:0] mode_q;
    logic [3:0]        bl_q;
    logic [1:0]        cl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              e_mode_q, e_field_q, e_seq_q, e_proto_q;
    logic [3:0]        code_q;
    logic              new_mode, new_field, new_seq, new_proto, any_err;

    sdm_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdm_mode_check u_mode (
        .bl_code    (addr[2:0]),
        .interleave (addr[3]),
        .cl_code    (addr[6:4]),
        .op_code    (addr[8:7]),
        .rsv_code   (addr[11:10]),
        .bl_bad     (bl_bad),
        .cl_bad     (cl_bad),
        .op_bad     (op_bad),
        .field_bad  (field_bad),
        .bl_val     (bl_val),
        .cl_val     (cl_val)
    );

    sdm_bank_track #(.BA_W(BA_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (open_en),
        .close_en  (close_en),
        .close_all (close_all),
        .bank      (ba),
        .open_q    (open_q),
        .sel_open  (sel_open),
        .last_open (last_open)
    );

    assign mode_ok  = !(bl_bad || cl_bad || op_bad || field_bad);
    assign lmr_seen = (cmd == CMD_LMR) && (st_q != ST_SELFREF);

    // Next-state and sequencing checks
    always_comb begin
        st_n       = st_q;
        ec         = EC_NONE;
        open_en    = 1'b0;
        close_en   = 1'b0;
        close_all  = 1'b0;
        accept_lmr = 1'b0;
        unique case (st_q)
            ST_UNINIT: begin
                unique case (cmd)
                    CMD_PRE:        st_n = ST_PRECHG;
                    CMD_RD, CMD_WR: ec = EC_EARLY;
                    CMD_NOP:        ;
                    default:        ec = EC_STATE;
                endcase
            end
            ST_PRECHG: begin
                unique case (cmd)
                    CMD_LMR:                   accept_lmr = 1'b1;
                    CMD_RD, CMD_WR:            ec = EC_EARLY;
                    CMD_PRE, CMD_AREF, CMD_NOP: ;
                    default:                   ec = EC_STATE;
                endcase
            end
            ST_MODESET: begin
                st_n = ST_IDLE;
                if (cmd != CMD_NOP) ec = EC_STATE;
            end
            ST_IDLE: begin
                unique case (cmd)
                    CMD_ACT: begin
                        open_en = 1'b1;
                        st_n    = ST_ACTIVE;
                    end
                    CMD_RD, CMD_WR: ec = EC_CLOSED;
                    CMD_LMR:        accept_lmr = 1'b1;
                    CMD_SREF:       st_n = ST_SELFREF;
                    default:        ;
                endcase
            end
            ST_ACTIVE: begin
                unique case (cmd)
                    CMD_ACT: begin
                        if (sel_open) ec = EC_REOPEN;
                        else          open_en = 1'b1;
                    end
                    CMD_RD, CMD_WR: begin
                        if (!sel_open) ec = EC_CLOSED;
                    end
                    CMD_PRE: begin
                        if (addr[AP_BIT]) begin
                            close_all = 1'b1;
                            st_n      = ST_IDLE;
                        end else begin
                            close_en = 1'b1;
                            if (last_open) st_n = ST_IDLE;
                        end
                    end
                    CMD_BST, CMD_NOP: ;
                    default:          ec = EC_STATE;
                endcase
            end
            ST_SELFREF: begin
                if (cke) st_n = ST_IDLE;
            end
            default: st_n = ST_UNINIT;
        endcase
        if (accept_lmr && mode_ok) st_n = ST_MODESET;
    end

    // Mode-word error code, lowest code first
    always_comb begin
        mec = EC_NONE;
        if (lmr_seen) begin
            if (bl_bad)         mec = EC_BL;
            else if (cl_bad)    mec = EC_CL;
            else if (op_bad)    mec = EC_OP;
            else if (field_bad) mec = EC_FIELD;
        end
    end

    assign new_code  = (mec != EC_NONE) ? mec : ec;
    assign new_mode  = lmr_seen && (bl_bad || cl_bad || op_bad);
    assign new_field = lmr_seen && field_bad;
    assign new_seq   = (ec == EC_EARLY) || (ec == EC_STATE);
    assign new_proto = (ec == EC_CLOSED) || (ec == EC_REOPEN);
    assign any_err   = e_mode_q || e_field_q || e_seq_q || e_proto_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_UNINIT;
        else        st_q <= st_n;
    end

    // Shadow, counter and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            bl_q      <= '0;
            cl_q      <= '0;
            cnt_q     <= '0;
            e_mode_q  <= 1'b0;
            e_field_q <= 1'b0;
            e_seq_q   <= 1'b0;
            e_proto_q <= 1'b0;
            code_q    <= EC_NONE;
        end else begin
            if (accept_lmr && mode_ok) begin
                mode_q <= addr[MODE_W-1:0];
                bl_q   <= bl_val;
                cl_q   <= cl_val;
            end
            if (lmr_seen) cnt_q <= cnt_q + CNT_W'(1);
            e_mode_q  <= new_mode  || (e_mode_q  && !err_clr);
            e_field_q <= new_field || (e_field_q && !err_clr);
            e_seq_q   <= new_seq   || (e_seq_q   && !err_clr);
            e_proto_q <= new_proto || (e_proto_q && !err_clr);
            if ((err_clr || !any_err) && (new_code != EC_NONE)) code_q <= new_code;
            else if (err_clr)                                   code_q <= EC_NONE;
        end
    end

    assign state_o      = st_q;
    assign mode_word_o  = mode_q;
    assign burst_len_o  = bl_q;
    assign cas_lat_o    = cl_q;
    assign mode_loads_o = cnt_q;
    assign err_mode_o   = e_mode_q;
    assign err_field_o  = e_field_q;
    assign err_seq_o    = e_seq_q;
    assign err_proto_o  = e_proto_q;
    assign err_code_o   = code_q;

    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q inside {ST_UNINIT, ST_PRECHG, ST_MODESET, ST_IDLE, ST_ACTIVE, ST_SELFREF});

    p_modeset_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MODESET) |=> (st_q == ST_IDLE));

    p_bl_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bl_q));

    p_cl_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_q == 2'd0) || (cl_q == 2'd2) || (cl_q == 2'd3));

    p_reject_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr_seen && !mode_ok) |=> $stable(mode_q));

    p_idle_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (open_q == '0));

    p_active_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE) |-> (open_q != '0));

    p_sref_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SELFREF) && cke) |=> (st_q == ST_IDLE));

    p_sticky_proto_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (e_proto_q && !err_clr) |=> e_proto_q);

    p_count_step_r14: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_seen |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

endmodule

// File: tb/sdram_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module sdram_bus_monitor_tb_top;

    localparam int BA_W   = 2;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 3;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_INH = 4'b1101;

    localparam logic [11:0] W_DEF = 12'h022; // BL 4, CL 2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0] ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic err_clr = 1'b0;
    logic [2:0] state_o;
    logic [11:0] mode_word_o;
    logic [3:0] burst_len_o;
    logic [1:0] cas_lat_o;
    logic [CNT_W-1:0] mode_loads_o;
    logic err_mode_o, err_field_o, err_seq_o, err_proto_o;
    logic [3:0] err_code_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sdram_bus_monitor #(.BA_W(BA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .err_clr(err_clr),
        .state_o(state_o), .mode_word_o(mode_word_o), .burst_len_o(burst_len_o),
        .cas_lat_o(cas_lat_o), .mode_loads_o(mode_loads_o), .err_mode_o(err_mode_o),
        .err_field_o(err_field_o), .err_seq_o(err_seq_o), .err_proto_o(err_proto_o),
        .err_code_o(err_code_o)
    );

    task automatic chk(input string id, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", id, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                         input logic ck, input logic ck_after);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b; addr = a; cke = ck;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        ba = '0; addr = '0; cke = ck_after;
    endtask

    task automatic cmd(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
        issue(c, b, a, 1'b1, 1'b1);
    endtask

    task automatic clr_pulse();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        cke = 1'b1; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic go_idle();
        do_reset();
        cmd(C_PRE, 0, 12'h400);
        cmd(C_LMR, 0, W_DEF);
        cmd(C_NOP, 0, 0);
    endtask

    task automatic errs(input string id, input int m, input int f, input int s, input int p, input int code);
        chk({id, " err_mode"}, err_mode_o, m);
        chk({id, " err_field"}, err_field_o, f);
        chk({id, " err_seq"}, err_seq_o, s);
        chk({id, " err_proto"}, err_proto_o, p);
        chk({id, " code"}, err_code_o, code);
    endtask

    task automatic t_reset_r2();
        do_reset();
        chk("R2 state", state_o, 0);
        errs("R2", 0, 0, 0, 0, 0);
        chk("R2 bl", burst_len_o, 0);
        chk("R2 cl", cas_lat_o, 0);
        chk("R2 count", mode_loads_o, 0);
    endtask

    task automatic t_init_r3();
        do_reset();
        cmd(C_PRE, 0, 12'h400);
        chk("R3 precharged", state_o, 1);
        cmd(C_LMR, 0, W_DEF);
        chk("R3 mode set", state_o, 2);
        chk("R3 mode word", mode_word_o, W_DEF);
        cmd(C_NOP, 0, 0);
        chk("R3 idle", state_o, 3);
        errs("R3", 0, 0, 0, 0, 0);
    endtask

    task automatic t_burst_r4();
        int exp_bl [4] = '{1, 2, 4, 8};
        go_idle();
        for (int k = 0; k < 4; k++) begin
            cmd(C_LMR, 0, 12'h020 | 12'(k));
            cmd(C_NOP, 0, 0);
            chk("R4 burst length", burst_len_o, exp_bl[k]);
        end
        cmd(C_LMR, 0, 12'h027);
        cmd(C_NOP, 0, 0);
        chk("R4 full page", burst_len_o, 0);
        errs("R4 legal", 0, 0, 0, 0, 0);
        cmd(C_LMR, 0, 12'h024);
        errs("R4 code 100", 1, 0, 0, 0, 1);
        chk("R8 state kept", state_o, 3);
        chk("R8 mode word kept", mode_word_o, 12'h027);
        clr_pulse();
        cmd(C_LMR, 0, 12'h02F);
        errs("R4 interleaved 111", 1, 0, 0, 0, 1);
        chk("R8 burst kept", burst_len_o, 0);
        clr_pulse();
    endtask

    task automatic t_cas_r5();
        go_idle();
        cmd(C_LMR, 0, 12'h032);
        cmd(C_NOP, 0, 0);
        chk("R5 latency 3", cas_lat_o, 3);
        cmd(C_LMR, 0, 12'h022);
        cmd(C_NOP, 0, 0);
        chk("R5 latency 2", cas_lat_o, 2);
        cmd(C_LMR, 0, 12'h012);
        errs("R5 code 001", 1, 0, 0, 0, 2);
        chk("R8 latency kept", cas_lat_o, 2);
        clr_pulse();
        cmd(C_LMR, 0, 12'h072);
        errs("R5 code 111", 1, 0, 0, 0, 2);
        clr_pulse();
    endtask

    task automatic t_fields_r6_r7();
        go_idle();
        cmd(C_LMR, 0, 12'h0A2);
        errs("R6 op mode 01", 1, 0, 0, 0, 3);
        clr_pulse();
        cmd(C_LMR, 0, 12'h822);
        errs("R7 reserved field", 0, 1, 0, 0, 4);
        chk("R8 word kept", mode_word_o, W_DEF);
        chk("R8 still idle", state_o, 3);
        clr_pulse();
    endtask

    task automatic t_seq_r9();
        do_reset();
        cmd(C_RD, 0, 0);
        errs("R9 read in uninit", 0, 0, 1, 0, 5);
        clr_pulse();
        cmd(C_ACT, 0, 0);
        errs("R9 activate in uninit", 0, 0, 1, 0, 6);
        chk("R9 uninit held", state_o, 0);
        clr_pulse();
        cmd(C_PRE, 0, 12'h400);
        cmd(C_WR, 1, 0);
        errs("R9 write in precharged", 0, 0, 1, 0, 5);
        clr_pulse();
        cmd(C_LMR, 0, 12'h024);
        chk("R8 rejected stays precharged", state_o, 1);
        clr_pulse();
        cmd(C_LMR, 0, W_DEF);
        cmd(C_ACT, 2, 0);
        errs("R9 command in mode set", 0, 0, 1, 0, 6);
        chk("R9 mode set then idle", state_o, 3);
        clr_pulse();
        cmd(C_ACT, 0, 0);
        cmd(C_REF, 0, 0);
        errs("R9 refresh while active", 0, 0, 1, 0, 6);
        clr_pulse();
    endtask

    task automatic t_bank_r10_r11();
        go_idle();
        cmd(C_RD, 1, 0);
        errs("R10 read closed in idle", 0, 0, 0, 1, 7);
        clr_pulse();
        cmd(C_ACT, 1, 0);
        chk("R11 active", state_o, 4);
        cmd(C_RD, 1, 0);
        errs("R10 read open bank", 0, 0, 0, 0, 0);
        cmd(C_WR, 2, 0);
        errs("R10 write closed bank", 0, 0, 0, 1, 7);
        clr_pulse();
        cmd(C_ACT, 1, 0);
        errs("R10 reopen", 0, 0, 0, 1, 8);
        clr_pulse();
        cmd(C_ACT, 2, 0);
        cmd(C_PRE, 1, 0);
        chk("R11 one bank left", state_o, 4);
        cmd(C_RD, 1, 0);
        errs("R11 bank 1 closed", 0, 0, 0, 1, 7);
        clr_pulse();
        cmd(C_PRE, 2, 0);
        chk("R11 last bank closed", state_o, 3);
        cmd(C_ACT, 0, 0);
        cmd(C_ACT, 3, 0);
        cmd(C_PRE, 1, 12'h400);
        chk("R11 precharge all", state_o, 3);
        errs("R11 clean", 0, 0, 0, 0, 0);
    endtask

    task automatic t_decode_r1();
        go_idle();
        issue(C_ACT, 1, 0, 1'b0, 1'b1);
        chk("R1 cke low ignored", state_o, 3);
        cmd(C_INH, 1, 0);
        errs("R1 inhibit ignored", 0, 0, 0, 0, 0);
        cmd(C_RD, 1, 0);
        errs("R1 read decoded", 0, 0, 0, 1, 7);
        clr_pulse();
    endtask

    task automatic t_sref_r12();
        go_idle();
        cmd(C_REF, 0, 0);
        chk("R12 auto refresh stays idle", state_o, 3);
        issue(C_REF, 0, 0, 1'b0, 1'b0);
        chk("R12 self refresh", state_o, 5);
        issue(C_RD, 1, 0, 1'b0, 1'b0);
        issue(C_NOP, 0, 0, 1'b0, 1'b1);
        chk("R12 held", state_o, 5);
        errs("R12 nothing decoded", 0, 0, 0, 0, 0);
        cmd(C_NOP, 0, 0);
        chk("R12 exit", state_o, 3);
    endtask

    task automatic t_sticky_r13();
        go_idle();
        cmd(C_RD, 0, 0);
        cmd(C_ACT, 1, 0);
        cmd(C_ACT, 1, 0);
        cmd(C_LMR, 0, W_DEF);
        errs("R13 first kept", 0, 0, 1, 1, 7);
        clr_pulse();
        errs("R13 cleared", 0, 0, 0, 0, 0);
        chk("R13 state kept", state_o, 4);
        err_clr = 1'b1;
        cmd(C_ACT, 1, 0);
        err_clr = 1'b0;
        errs("R13 clear with error", 0, 0, 0, 1, 8);
        clr_pulse();
    endtask

    task automatic t_count_r14();
        do_reset();
        cmd(C_PRE, 0, 12'h400);
        cmd(C_LMR, 0, W_DEF);
        cmd(C_NOP, 0, 0);
        chk("R14 one load", mode_loads_o, 1);
        for (int k = 0; k < 6; k++) cmd(C_LMR, 0, 12'h000);
        chk("R14 rejected loads counted", mode_loads_o, 7);
        cmd(C_LMR, 0, 12'h000);
        chk("R14 wrap", mode_loads_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_r2();
        t_init_r3();
        t_decode_r1();
        t_burst_r4();
        t_cas_r5();
        t_fields_r6_r7();
        t_seq_r9();
        t_bank_r10_r11();
        t_sref_r12();
        t_sticky_r13();
        t_count_r14();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule